// File: doc/BRIEF.md
# Instruction Fetch Forwarding Controller

This block sits between a processor's instruction fetch port and a pipelined internal system bus. Each fetch is presented to this controller and to a separate protection checker in the same cycle. The controller acts as the parked master on the bus, so an accepted fetch leaves on the bus in the cycle it arrives. It chooses a burst or a single transfer from a configuration bit and the fetch's debug attribute. The debug, program-trace and show-cycle attributes travel with the request. Read beats coming back from the bus are relayed to the processor.

When the protection checker cancels a fetch, the controller drops it. The exception is a fetch that carries a program-trace or show-cycle attribute. Such a fetch still runs on the bus so that external observers can see it, but its data is withheld from the processor. Only one fetch is in flight at a time, and further fetches wait until the current transfer ends. A standby input puts the idle controller to sleep. The first fetch seen after standby is released wakes it.

Top module: `fetch_fwd_ctrl`

## Requirements
- R1: `bus_burst` is 1 on an issued request only when the burst-enable setting `cfg_burst_q` is 1 and the fetch is not a debug fetch. Otherwise the request is a single transfer.
- R2: A fetch with `cpu_dbg`=1 is always issued with `bus_burst`=0, whatever the burst-enable setting.
- R3: A fetch accepted together with `prot_cancel`=1 and with neither `cpu_trace` nor `cpu_show` set is acknowledged on `cpu_ack`, is never placed on the bus, and leaves the controller idle.
- R4: A fetch accepted together with `prot_cancel`=1 and with `cpu_trace` or `cpu_show` set is still issued on the bus. None of its returned beats reach `cpu_rvalid`.
- R5: `bus_dbg`, `bus_trace` and `bus_show` equal the attributes of the fetch being issued.
- R6: After a cycle with `rst_n`=0 the controller is idle, `cfg_burst_q` is 0 and `cpu_rvalid` is 0. Any transfer in progress is forgotten.
- R7: When idle and not in standby, a fetch (`cpu_req`=1) drives `bus_req`, `bus_addr` and the attributes in that same cycle, with `cpu_ack`=1.
- R8: Once issued, a request holds `bus_req`=1 with unchanged address and attributes until `bus_gnt`=1. From acceptance until the last beat, `cpu_ack` stays 0 and new fetches are stalled.
- R9: After grant, each `bus_rvalid` beat of a non-cancelled fetch appears on `cpu_rvalid`/`cpu_rdata` in the same cycle. The beat with `bus_rlast`=1 ends the transfer, and the next fetch can be accepted in the following cycle.
- R10: With `standby`=1 while idle, the controller sleeps from the next cycle, with `cpu_ack`=0 and `bus_req`=0. It stays asleep until a cycle with `standby`=0 and `cpu_req`=1. After that cycle it is idle again and accepts the fetch one cycle later.
- R11: A cycle with `cfg_we`=1 loads `cfg_burst_wr` into `cfg_burst_q` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| standby | input | 1 | Low-power request |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_burst_wr | input | 1 | Burst-enable value to write |
| cfg_burst_q | output | 1 | Current burst-enable setting |
| cpu_req | input | 1 | Fetch request from processor |
| cpu_addr | input | AW | Fetch address |
| cpu_dbg | input | 1 | Debug-port fetch attribute |
| cpu_trace | input | 1 | Program-trace attribute |
| cpu_show | input | 1 | Show-cycle attribute |
| prot_cancel | input | 1 | Cancel from protection checker, valid with cpu_req |
| cpu_ack | output | 1 | Fetch accepted this cycle |
| cpu_rvalid | output | 1 | Fetch data beat valid |
| cpu_rdata | output | DW | Fetch data beat |
| bus_req | output | 1 | Bus transfer request |
| bus_gnt | input | 1 | Bus address phase granted |
| bus_addr | output | AW | Bus transfer address |
| bus_burst | output | 1 | Burst transfer requested |
| bus_dbg | output | 1 | Debug attribute on bus |
| bus_trace | output | 1 | Program-trace attribute on bus |
| bus_show | output | 1 | Show-cycle attribute on bus |
| bus_rvalid | input | 1 | Read beat valid from bus |
| bus_rlast | input | 1 | Last beat of the transfer |
| bus_rdata | input | DW | Read beat data |

## Verification
The bound assertions check on every cycle the rules that concern the burst decision (R1, R2). They also check that a stalled request holds steady until grant (R8), that returned data comes only from a live bus beat (R9), and the state right after reset (R6). Other behaviours depend on sequences of inputs across several cycles: dropping versus shadow-forwarding of cancelled fetches, withholding of shadow data, sleep and wake-up timing, the stall of a held fetch, and config writes. These are shown only by the bench's scenarios, which compare every output each cycle against a behavioural model.

// File: rtl/fwd_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the fetch forwarding controller.
// Assumes: nothing beyond IEEE 1800-2017.
package fwd_pkg;

    // Controller sequencing state
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADDR  = 2'd1,
        ST_DATA  = 2'd2,
        ST_SLEEP = 2'd3
    } fwd_state_t;

    // Attributes carried from the fetch port to the bus
    typedef struct packed {
        logic dbg;
        logic trace;
        logic show;
    } fetch_attr_t;

endpackage

// File: rtl/fwd_cfg.sv
`timescale 1ns/1ps
// Module: fwd_cfg
// Holds the burst-enable setting. The write strobe loads a new value; reset clears it.
// Assumes: synchronous active-low reset that overrides a write in the same cycle.
module fwd_cfg (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic wdata,
    output logic burst_en
);

    // Burst-enable register
    always_ff @(posedge clk) begin
        if (!rst_n)
            burst_en <= 1'b0;
        else if (we)
            burst_en <= wdata;
    end

endmodule

// File: rtl/fwd_req_fmt.sv
`timescale 1ns/1ps
// Module: fwd_req_fmt
// Combinational classification of an incoming fetch: burst or single, and
// whether a cancel drops it or lets it through as an observable shadow fetch.
// Assumes: cancel is valid in the same cycle as the fetch request.
module fwd_req_fmt
    import fwd_pkg::*;
(
    input  logic        burst_en,
    input  fetch_attr_t attr,
    input  logic        cancel,
    output logic        want_burst,
    output logic        drop,
    output logic        shadow
);

    logic observable;

    // Decide burst and cancel handling for the fetch
    always_comb begin
        observable = attr.trace | attr.show;
        want_burst = burst_en & ~attr.dbg;
        drop       = cancel & ~observable;
        shadow     = cancel & observable;
    end

endmodule

// File: rtl/fwd_seq.sv
`timescale 1ns/1ps
// Module: fwd_seq
// Sequencer: accepts one fetch at a time, drives the bus as the parked master,
// holds the request until grant, relays beats until the last one, and sleeps in standby.
// Assumes: the bus keeps rvalid low outside the data phase of the granted transfer.
module fwd_seq
    import fwd_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          standby,
    input  logic          cpu_req,
    input  logic [AW-1:0] cpu_addr,
    input  fetch_attr_t   cpu_attr,
    input  logic          want_burst,
    input  logic          drop,
    input  logic          shadow,
    output logic          cpu_ack,
    output logic          cpu_rvalid,
    output logic [DW-1:0] cpu_rdata,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic [AW-1:0] bus_addr,
    output logic          bus_burst,
    output fetch_attr_t   bus_attr,
    input  logic          bus_rvalid,
    input  logic          bus_rlast,
    input  logic [DW-1:0] bus_rdata
);

    fwd_state_t    state_q, state_d;
    logic [AW-1:0] addr_q;
    fetch_attr_t   attr_q;
    logic          burst_q;
    logic          shadow_q;
    logic          take;
    logic          issue;
    logic          holding;

    // Acceptance and issue decisions for this cycle
    always_comb begin
        take    = (state_q == ST_IDLE) && !standby && cpu_req;
        issue   = take && !drop;
        holding = (state_q == ST_ADDR);
    end

    // Bus and processor-side outputs
    always_comb begin
        cpu_ack    = take;
        bus_req    = issue || holding;
        bus_addr   = holding ? addr_q  : cpu_addr;
        bus_attr   = holding ? attr_q  : cpu_attr;
        bus_burst  = holding ? burst_q : want_burst;
        cpu_rvalid = (state_q == ST_DATA) && bus_rvalid && !shadow_q;
        cpu_rdata  = bus_rdata;
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (standby)
                    state_d = ST_SLEEP;
                else if (issue)
                    state_d = bus_gnt ? ST_DATA : ST_ADDR;
            end
            ST_ADDR:  if (bus_gnt) state_d = ST_DATA;
            ST_DATA:  if (bus_rvalid && bus_rlast) state_d = ST_IDLE;
            ST_SLEEP: if (!standby && cpu_req) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Capture the issued fetch so it stays stable until the transfer ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            attr_q   <= '0;
            burst_q  <= 1'b0;
            shadow_q <= 1'b0;
        end else if (issue) begin
            addr_q   <= cpu_addr;
            attr_q   <= cpu_attr;
            burst_q  <= want_burst;
            shadow_q <= shadow;
        end
    end

endmodule

// File: rtl/fetch_fwd_ctrl.sv
`timescale 1ns/1ps
// Module: fetch_fwd_ctrl (top)
// Forwards processor instruction fetches onto the system bus with burst choice,
// attribute pass-through, cancel handling and standby sleep.
// Assumes: prot_cancel is produced combinationally for the fetch presented on cpu_req.
module fetch_fwd_ctrl
    import fwd_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          standby,
    input  logic          cfg_we,
    input  logic          cfg_burst_wr,
    output logic          cfg_burst_q,
    input  logic          cpu_req,
    input  logic [AW-1:0] cpu_addr,
    input  logic          cpu_dbg,
    input  logic          cpu_trace,
    input  logic          cpu_show,
    input  logic          prot_cancel,
    output logic          cpu_ack,
    output logic          cpu_rvalid,
    output logic [DW-1:0] cpu_rdata,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic [AW-1:0] bus_addr,
    output logic          bus_burst,
    output logic          bus_dbg,
    output logic          bus_trace,
    output logic          bus_show,
    input  logic          bus_rvalid,
    input  logic          bus_rlast,
    input  logic [DW-1:0] bus_rdata
);

    fetch_attr_t in_attr;
    fetch_attr_t out_attr;
    logic        want_burst;
    logic        drop;
    logic        shadow;

    // Pack incoming attributes and unpack outgoing ones
    always_comb begin
        in_attr   = '{dbg: cpu_dbg, trace: cpu_trace, show: cpu_show};
        bus_dbg   = out_attr.dbg;
        bus_trace = out_attr.trace;
        bus_show  = out_attr.show;
    end

    fwd_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .wdata    (cfg_burst_wr),
        .burst_en (cfg_burst_q)
    );

    fwd_req_fmt u_fmt (
        .burst_en   (cfg_burst_q),
        .attr       (in_attr),
        .cancel     (prot_cancel),
        .want_burst (want_burst),
        .drop       (drop),
        .shadow     (shadow)
    );

    fwd_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .standby    (standby),
        .cpu_req    (cpu_req),
        .cpu_addr   (cpu_addr),
        .cpu_attr   (in_attr),
        .want_burst (want_burst),
        .drop       (drop),
        .shadow     (shadow),
        .cpu_ack    (cpu_ack),
        .cpu_rvalid (cpu_rvalid),
        .cpu_rdata  (cpu_rdata),
        .bus_req    (bus_req),
        .bus_gnt    (bus_gnt),
        .bus_addr   (bus_addr),
        .bus_burst  (bus_burst),
        .bus_attr   (out_attr),
        .bus_rvalid (bus_rvalid),
        .bus_rlast  (bus_rlast),
        .bus_rdata  (bus_rdata)
    );

endmodule

// File: rtl/fwd_chk.sv
`timescale 1ns/1ps
// Module: fwd_chk
// Port-level properties of fetch_fwd_ctrl, attached by bind.
// Assumes: sampled on the rising clock edge with synchronous active-low reset.
module fwd_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_burst_q,
    input logic          cpu_rvalid,
    input logic [DW-1:0] cpu_rdata,
    input logic          bus_req,
    input logic          bus_gnt,
    input logic [AW-1:0] bus_addr,
    input logic          bus_burst,
    input logic          bus_dbg,
    input logic          bus_rvalid,
    input logic [DW-1:0] bus_rdata
);

    // R1
    burst_needs_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_burst) |-> cfg_burst_q);

    // R2
    dbg_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_dbg) |-> !bus_burst);

    // R8
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr)));

    // R9
    rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |-> (bus_rvalid && cpu_rdata == bus_rdata));

    // R6
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!cfg_burst_q && !cpu_rvalid));

endmodule

bind fetch_fwd_ctrl fwd_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_burst_q (cfg_burst_q),
    .cpu_rvalid  (cpu_rvalid),
    .cpu_rdata   (cpu_rdata),
    .bus_req     (bus_req),
    .bus_gnt     (bus_gnt),
    .bus_addr    (bus_addr),
    .bus_burst   (bus_burst),
    .bus_dbg     (bus_dbg),
    .bus_rvalid  (bus_rvalid),
    .bus_rdata   (bus_rdata)
);

// File: tb/fetch_fwd_ctrl_tb.sv
`timescale 1ns/1ps
module fetch_fwd_ctrl_tb;

    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          standby = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_burst_wr = 1'b0;
    logic          cfg_burst_q;
    logic          cpu_req = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic          cpu_dbg = 1'b0;
    logic          cpu_trace = 1'b0;
    logic          cpu_show = 1'b0;
    logic          prot_cancel = 1'b0;
    logic          cpu_ack;
    logic          cpu_rvalid;
    logic [DW-1:0] cpu_rdata;
    logic          bus_req;
    logic          bus_gnt = 1'b0;
    logic [AW-1:0] bus_addr;
    logic          bus_burst;
    logic          bus_dbg;
    logic          bus_trace;
    logic          bus_show;
    logic          bus_rvalid = 1'b0;
    logic          bus_rlast = 1'b0;
    logic [DW-1:0] bus_rdata = '0;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    // Behavioural reference: 0 idle, 1 waiting grant, 2 data, 3 asleep
    int            mode = 0;
    logic [AW-1:0] m_addr = '0;
    logic          m_dbg = 0, m_tr = 0, m_sh = 0, m_burst = 0, m_shadow = 0, m_cfg = 0;

    always #2.5 clk = ~clk;

    fetch_fwd_ctrl #(.AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .standby(standby),
        .cfg_we(cfg_we), .cfg_burst_wr(cfg_burst_wr), .cfg_burst_q(cfg_burst_q),
        .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_dbg(cpu_dbg),
        .cpu_trace(cpu_trace), .cpu_show(cpu_show), .prot_cancel(prot_cancel),
        .cpu_ack(cpu_ack), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_addr(bus_addr),
        .bus_burst(bus_burst), .bus_dbg(bus_dbg), .bus_trace(bus_trace),
        .bus_show(bus_show), .bus_rvalid(bus_rvalid), .bus_rlast(bus_rlast),
        .bus_rdata(bus_rdata)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the model, away from the active edge
    always @(negedge clk) begin
        logic e_take, e_drop, e_req, e_burst, e_dbg, e_tr, e_sh, e_rv;
        logic [AW-1:0] e_addr;
        #1;
        if (rst_n && !done) begin
            e_take  = (mode == 0) && !standby && cpu_req;
            e_drop  = prot_cancel && !(cpu_trace || cpu_show);
            e_req   = (e_take && !e_drop) || (mode == 1);
            e_burst = (mode == 1) ? m_burst : (m_cfg && !cpu_dbg);
            e_addr  = (mode == 1) ? m_addr  : cpu_addr;
            e_dbg   = (mode == 1) ? m_dbg   : cpu_dbg;
            e_tr    = (mode == 1) ? m_tr    : cpu_trace;
            e_sh    = (mode == 1) ? m_sh    : cpu_show;
            e_rv    = (mode == 2) && bus_rvalid && !m_shadow;
            chk(cpu_ack == e_take, (mode == 3) ? "R10 ack" : "R8 ack", cpu_ack, e_take);
            chk(bus_req == e_req,
                (e_take && e_drop) ? "R3 req" : ((mode == 3) ? "R10 req" : "R7 req"),
                bus_req, e_req);
            if (e_req) begin
                chk(bus_burst == e_burst, e_dbg ? "R2 burst" : "R1 burst", bus_burst, e_burst);
                chk(bus_addr == e_addr, "R8 addr", bus_addr, e_addr);
                chk({bus_dbg, bus_trace, bus_show} == {e_dbg, e_tr, e_sh}, "R5 attr",
                    {bus_dbg, bus_trace, bus_show}, {e_dbg, e_tr, e_sh});
            end
            chk(cpu_rvalid == e_rv, m_shadow ? "R4 rvalid" : "R9 rvalid", cpu_rvalid, e_rv);
            if (e_rv) chk(cpu_rdata == bus_rdata, "R9 rdata", cpu_rdata, bus_rdata);
            chk(cfg_burst_q == m_cfg, "R11 cfg", cfg_burst_q, m_cfg);
        end
    end

    // Advance the model on each rising edge
    always @(posedge clk) begin
        logic drop_now;
        cyc++;
        if (!rst_n) begin
            mode  = 0;
            m_cfg = 0;
            m_shadow = 0;
        end else begin
            drop_now = prot_cancel && !(cpu_trace || cpu_show);
            case (mode)
                0: begin
                    if (standby) mode = 3;
                    else if (cpu_req && !drop_now) begin
                        m_addr = cpu_addr; m_dbg = cpu_dbg; m_tr = cpu_trace; m_sh = cpu_show;
                        m_burst = m_cfg && !cpu_dbg;
                        m_shadow = prot_cancel;
                        mode = bus_gnt ? 2 : 1;
                    end
                end
                1: if (bus_gnt) mode = 2;
                2: if (bus_rvalid && bus_rlast) mode = 0;
                default: if (!standby && cpu_req) mode = 0;
            endcase
            if (cfg_we) m_cfg = cfg_burst_wr;
        end
    end

    task automatic fetch(input logic [AW-1:0] a, input bit dbg, input bit tr, input bit sh,
                         input bit cancel, input int gdly, input int beats, input bit hold);
        bit dropped;
        dropped = cancel && !(tr || sh);
        @(negedge clk);
        cpu_req = 1; cpu_addr = a; cpu_dbg = dbg; cpu_trace = tr; cpu_show = sh;
        prot_cancel = cancel; bus_gnt = (gdly == 0) && !dropped;
        for (int k = 1; k <= gdly && !dropped; k++) begin
            @(negedge clk);
            if (!hold) begin cpu_req = 0; prot_cancel = 0; end
            cpu_addr = cpu_addr + (hold ? 32'h40 : 32'h0);
            bus_gnt = (k == gdly);
        end
        @(negedge clk);
        if (!hold) cpu_req = 0;
        prot_cancel = 0; bus_gnt = 0;
        if (dropped) return;
        for (int b = 0; b < beats; b++) begin
            bus_rvalid = 1; bus_rdata = a ^ (32'h1111 * (b + 1)); bus_rlast = (b == beats - 1);
            @(negedge clk);
        end
        bus_rvalid = 0; bus_rlast = 0;
    endtask

    task automatic set_cfg(input bit v);
        @(negedge clk);
        cfg_we = 1; cfg_burst_wr = v;
        @(negedge clk);
        cfg_we = 0;
    endtask

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL R8 watchdog act=%0d exp=%0d", cyc, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // Reset, with a config write that reset must override
        cfg_we = 1; cfg_burst_wr = 1;
        repeat (3) @(negedge clk);
        cfg_we = 0;
        rst_n = 1;
        #1;
        chk(!bus_req && !cpu_rvalid && !cfg_burst_q && !cpu_ack, "R6 reset",
            {bus_req, cpu_rvalid, cfg_burst_q, cpu_ack}, 0);

        // Single transfers with burst disabled (R1, R7, R9)
        fetch(32'h0000_1000, 0, 0, 0, 0, 0, 1, 0);
        fetch(32'h0000_2000, 0, 1, 0, 0, 2, 1, 0);
        // Burst enabled: burst request, multi-beat, delayed grant (R11, R1, R8)
        set_cfg(1);
        fetch(32'h0000_3000, 0, 0, 0, 0, 3, 4, 0);
        // Debug fetch: forced single (R2, R5)
        fetch(32'h0000_4000, 1, 0, 1, 0, 1, 1, 0);
        // Cancelled plain fetch dropped (R3)
        fetch(32'h0000_5000, 0, 0, 0, 1, 0, 0, 0);
        // Cancelled fetch with trace / show still issued, data withheld (R4)
        fetch(32'h0000_6000, 0, 1, 0, 1, 1, 4, 0);
        fetch(32'h0000_7000, 1, 0, 1, 1, 0, 1, 0);
        // Held request stalls while busy (R8), then starts after last beat
        fetch(32'h0000_8000, 0, 0, 0, 0, 2, 2, 1);
        @(negedge clk); cpu_req = 0; bus_gnt = 1;
        @(negedge clk); bus_gnt = 0; bus_rvalid = 1; bus_rlast = 1; bus_rdata = 32'hCAFE;
        @(negedge clk); bus_rvalid = 1; bus_rlast = 1; bus_rdata = 32'hBEEF;
        @(negedge clk); bus_rvalid = 0; bus_rlast = 0;
        // Standby sleep and wake-up (R10)
        @(negedge clk); standby = 1;
        @(negedge clk); cpu_req = 1; cpu_addr = 32'h0000_9000;
        @(negedge clk);
        @(negedge clk); standby = 0;
        @(negedge clk); bus_gnt = 1;
        @(negedge clk); cpu_req = 0; bus_gnt = 0; bus_rvalid = 1; bus_rlast = 0; bus_rdata = 32'h1;
        @(negedge clk); bus_rlast = 1; bus_rdata = 32'h2;
        @(negedge clk); bus_rvalid = 0; bus_rlast = 0;
        // Burst off again, mixed traffic
        set_cfg(0);
        for (int i = 0; i < 12; i++)
            fetch(32'h1000_0000 + i * 32'h20, i[0], i[1], i[2], (i % 3) == 0, i % 3, 1 + (i % 4), 0);
        // Mid-transfer reset forgets the transfer (R6)
        fetch(32'h2000_0000, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        #1;
        chk(!bus_req && !cpu_rvalid && !cfg_burst_q, "R6 reset mid", {bus_req, cpu_rvalid}, 0);
        fetch(32'h3000_0000, 0, 0, 0, 0, 0, 1, 0);
        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule